// File: doc/BRIEF.md
# Check-Before-Retire Result Buffer

This block is a circular result store that advances in lock step with a reorder buffer. Each instruction gets a slot when it is dispatched. The out-of-order pipeline later writes the instruction's result into that slot. After that, an independent checker writes its recomputed result for the same slot. The two values are compared as soon as the checker's value arrives. An instruction may leave the buffer only when its recomputed result has matched the recorded one. Instructions always leave in program order, and up to a fixed number of them (eight by default) can leave in one cycle.

When a recomputed result disagrees with the recorded one, the entry is marked as faulty. Older entries keep retiring as normal. Once the faulty entry becomes the oldest one, the block raises a soft exception that carries the entry's program counter and slot index. On the next clock edge every entry is discarded, so execution can restart at that instruction. The slot of the faulty instruction becomes the next slot handed out.

The number of entries is the only limit on how far the main pipeline can run ahead of the checker. When every slot is occupied, the block asks dispatch to stall.

Top module: `crb_check_retire`

## Requirements
- R1: After reset the buffer is empty. `dispatch_stall`, `exc_valid`, `proto_err` and `ret_cnt` are 0, and `alloc_tag` is 0.
- R2: An allocation is accepted when `alloc_valid` is 1 and `dispatch_stall` is 0. The slot it receives is `alloc_tag`, read in the same cycle. Successive accepted allocations receive consecutive slot indices that wrap modulo DEPTH.
- R3: `dispatch_stall` is 1 when DEPTH entries are occupied and also in any cycle where `exc_valid` is 1. An allocation requested while `dispatch_stall` is 1 is dropped and does not move `alloc_tag`.
- R4: An entry never retires unless it has been completed and then checked with a recomputed value equal to its recorded result. An entry that is only completed stays in the buffer.
- R5: Retirement follows program order. `ret_base` is the oldest slot. `ret_cnt` is the length of the run of consecutive matching, checked entries that starts at the oldest slot, capped at RET_W. Those entries leave at the next clock edge.
- R6: When the oldest entry is checked and mismatched, `exc_valid` is 1. `exc_pc` and `exc_tag` then carry that entry's dispatch program counter and slot, and `ret_cnt` is 0.
- R7: The cycle after `exc_valid` the buffer is empty, and the next slot handed out is the faulty entry's slot.
- R8: A mismatched entry that is not the oldest raises no exception. Older matching entries still retire, and the exception appears only once the faulty entry is the oldest.
- R9: A checker write to a slot that is unoccupied or not yet completed sets `proto_err` in that cycle and leaves the entry unchecked.
- R10: Occupancy never exceeds DEPTH. Run-ahead of the main pipeline is bounded only by this capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_pc | input | PC_W | Program counter of the dispatched instruction |
| alloc_tag | output | log2(DEPTH) | Slot handed to the next accepted allocation |
| dispatch_stall | output | 1 | Buffer full or exception in progress |
| cmp_valid | input | 1 | Main pipeline completion write |
| cmp_tag | input | log2(DEPTH) | Slot being completed |
| cmp_data | input | DATA_W | Result from the main pipeline |
| chk_valid | input | 1 | Checker result write |
| chk_tag | input | log2(DEPTH) | Slot being checked |
| chk_data | input | DATA_W | Recomputed result from the checker |
| ret_cnt | output | log2(RET_W+1) | Number of entries retiring this cycle |
| ret_base | output | log2(DEPTH) | Slot of the oldest entry (first retiring one) |
| exc_valid | output | 1 | Soft exception for the oldest entry |
| exc_pc | output | PC_W | Program counter of the faulty entry |
| exc_tag | output | log2(DEPTH) | Slot of the faulty entry |
| proto_err | output | 1 | Checker wrote a slot that was not completed |

## Verification
The bench drives the buffer until it is full and holds it there. A design that let a dropped allocation advance the slot index would hand the same slot to two instructions. Retirement bursts are created that wrap past the last slot and that are cut short by an unchecked or mismatched entry. These catch a scan that skips a hole or retires a faulty entry. Mismatches are also placed behind matching entries, and checker writes are made to slots that are not completed. These expose an exception raised too early, a flush that fails to rewind the allocation slot, and a premature check that is silently accepted.

// File: rtl/crb_pkg.sv
package crb_pkg;

  // Per-entry status kept beside each recorded result.
  typedef struct packed {
    logic valid;   // slot holds an in-flight instruction
    logic done;    // main pipeline result recorded
    logic chkd;    // checker value compared
    logic bad;     // compared values differed
  } crb_flags_t;

  // Entry can leave the buffer: checked and equal.
  function automatic logic crb_ready(input crb_flags_t f);
    return f.valid && f.chkd && !f.bad;
  endfunction

  // Entry needs a restart once it is oldest.
  function automatic logic crb_fault(input crb_flags_t f);
    return f.valid && f.chkd && f.bad;
  endfunction

  // A checker write is legal only on a completed, occupied slot.
  function automatic logic crb_chk_legal(input crb_flags_t f);
    return f.valid && f.done;
  endfunction

endpackage

// File: rtl/crb_store.sv
module crb_store
  import crb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [DEPTH-1:0]             ret_clr,
  input  logic                         alloc_fire,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [PC_W-1:0]              alloc_pc,
  input  logic                         cmp_valid,
  input  logic [IDX_W-1:0]             cmp_tag,
  input  logic [DATA_W-1:0]            cmp_data,
  input  logic                         chk_valid,
  input  logic [IDX_W-1:0]             chk_tag,
  input  logic [DATA_W-1:0]            chk_data,
  output crb_flags_t [DEPTH-1:0]       flags_o,
  output logic [DEPTH-1:0][PC_W-1:0]   pcs_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    crb_flags_t        f_q;
    logic [DATA_W-1:0] res_q;
    logic [PC_W-1:0]   pc_q;
    logic              hit_alloc, hit_cmp, hit_chk;

    assign hit_alloc = alloc_fire && (alloc_idx == IDX_W'(e));
    assign hit_cmp   = cmp_valid && (cmp_tag == IDX_W'(e)) && f_q.valid;
    assign hit_chk   = chk_valid && (chk_tag == IDX_W'(e)) && crb_chk_legal(f_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q   <= '0;
        res_q <= '0;
        pc_q  <= '0;
      end else if (flush || ret_clr[e]) begin
        f_q <= '0;
      end else if (hit_alloc) begin
        f_q  <= '{valid: 1'b1, default: 1'b0};
        pc_q <= alloc_pc;
      end else begin
        if (hit_cmp) begin
          f_q.done <= 1'b1;
          res_q    <= cmp_data;
        end
        if (hit_chk) begin
          f_q.chkd <= 1'b1;
          f_q.bad  <= (chk_data != res_q);
        end
      end
    end

    assign flags_o[e] = f_q;
    assign pcs_o[e]   = pc_q;

    // R4: the retire scan only clears entries that matched their check
    a_r4_retire_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ret_clr[e] |-> (f_q.valid && f_q.chkd && !f_q.bad));

    // R9: a premature checker write leaves the slot unchecked
    a_r9_early_check_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_tag == IDX_W'(e) && !f_q.done) |=> !f_q.chkd);
  end

endmodule

// File: rtl/crb_retire_scan.sv
module crb_retire_scan
  import crb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int RET_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RCW   = $clog2(RET_W + 1)
) (
  input  crb_flags_t [DEPTH-1:0] flags,
  input  logic [IDX_W-1:0]       head,
  output logic [RCW-1:0]         ret_cnt,
  output logic [DEPTH-1:0]       ret_clr,
  output logic                   fault
);

  logic [RET_W-1:0]            run;
  logic [RET_W-1:0][IDX_W-1:0] slot;

  for (genvar i = 0; i < RET_W; i++) begin : g_slot
    assign slot[i] = head + IDX_W'(i);
    if (i == 0) begin : g_first
      assign run[i] = crb_ready(flags[slot[i]]);
    end else begin : g_rest
      assign run[i] = run[i-1] && crb_ready(flags[slot[i]]);
    end
  end

  always_comb begin
    ret_clr = '0;
    ret_cnt = '0;
    for (int i = 0; i < RET_W; i++) begin
      if (run[i]) begin
        ret_clr[slot[i]] = 1'b1;
        ret_cnt          = ret_cnt + RCW'(1);
      end
    end
  end

  assign fault = crb_fault(flags[head]);

endmodule

// File: rtl/crb_ptrs.sv
module crb_ptrs #(
  parameter int DEPTH = 64,
  parameter int RET_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RCW   = $clog2(RET_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic [RCW-1:0]   ret_cnt,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             stall,
  output logic             alloc_fire
);

  assign stall      = (occ == CNT_W'(DEPTH)) || flush;
  assign alloc_fire = alloc_req && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (flush) begin
      tail <= head;
      occ  <= '0;
    end else begin
      head <= head + IDX_W'(ret_cnt);
      tail <= tail + IDX_W'(alloc_fire);
      occ  <= occ - CNT_W'(ret_cnt) + CNT_W'(alloc_fire);
    end
  end

  // R10: occupancy is capped by capacity
  a_r10_occ_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R3: a full buffer does not hand out a new slot
  a_r3_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && alloc_req) |=> (tail == $past(tail)));

  // R7: the exception empties the buffer and rewinds allocation
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0 && tail == head));

endmodule

// File: rtl/crb_check_retire.sv
module crb_check_retire
  import crb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int RET_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RCW   = $clog2(RET_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [IDX_W-1:0]  alloc_tag,
  output logic              dispatch_stall,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_tag,
  input  logic [DATA_W-1:0] chk_data,
  output logic [RCW-1:0]    ret_cnt,
  output logic [IDX_W-1:0]  ret_base,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc,
  output logic [IDX_W-1:0]  exc_tag,
  output logic              proto_err
);

  crb_flags_t [DEPTH-1:0]     flags;
  logic [DEPTH-1:0][PC_W-1:0] pcs;
  logic [DEPTH-1:0]           ret_clr;
  logic [IDX_W-1:0]           head, tail;
  logic [CNT_W-1:0]           occ;
  logic                       alloc_fire, fault;

  crb_ptrs #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_valid),
    .ret_cnt    (ret_cnt),
    .flush      (fault),
    .head       (head),
    .tail       (tail),
    .occ        (occ),
    .stall      (dispatch_stall),
    .alloc_fire (alloc_fire)
  );

  crb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PC_W(PC_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fault),
    .ret_clr    (ret_clr),
    .alloc_fire (alloc_fire),
    .alloc_idx  (tail),
    .alloc_pc   (alloc_pc),
    .cmp_valid  (cmp_valid),
    .cmp_tag    (cmp_tag),
    .cmp_data   (cmp_data),
    .chk_valid  (chk_valid),
    .chk_tag    (chk_tag),
    .chk_data   (chk_data),
    .flags_o    (flags),
    .pcs_o      (pcs)
  );

  crb_retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
    .flags   (flags),
    .head    (head),
    .ret_cnt (ret_cnt),
    .ret_clr (ret_clr),
    .fault   (fault)
  );

  assign alloc_tag = tail;
  assign ret_base  = head;
  assign exc_valid = fault;
  assign exc_tag   = head;
  assign exc_pc    = pcs[head];
  assign proto_err = chk_valid && !crb_chk_legal(flags[chk_tag]);

  // R5: never retire more entries than are occupied
  a_r5_retire_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(ret_cnt) <= occ);

  // R6: an exception cycle retires nothing
  a_r6_exc_blocks_retire: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (ret_cnt == '0));

endmodule

// File: tb/crb_check_retire_bench.sv
module crb_check_retire_bench;

  localparam int DEPTH = 64;
  localparam int RET_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [31:0] alloc_pc = '0;
  logic [5:0]  alloc_tag;
  logic        dispatch_stall;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_tag = '0;
  logic [31:0] cmp_data = '0;
  logic        chk_valid = 1'b0;
  logic [5:0]  chk_tag = '0;
  logic [31:0] chk_data = '0;
  logic [3:0]  ret_cnt;
  logic [5:0]  ret_base;
  logic        exc_valid;
  logic [31:0] exc_pc;
  logic [5:0]  exc_tag;
  logic        proto_err;

  crb_check_retire u_crb_check_retire (.*);

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  bit          mv[DEPTH], md[DEPTH], mc[DEPTH], mb[DEPTH];
  logic [31:0] mres[DEPTH], mpc[DEPTH];
  int          mh = 0, mt = 0, mn = 0;
  bit          e_exc, e_stall;
  int          e_rc;

  int p_alloc, p_cmp, p_chk, p_bad, p_proto;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_now();
    e_exc   = mv[mh] && mc[mh] && mb[mh];
    e_stall = (mn == DEPTH) || e_exc;
    e_rc = 0;
    for (int i = 0; i < RET_W && i < mn; i++) begin
      int k = (mh + i) % DEPTH;
      if (mv[k] && mc[k] && !mb[k]) e_rc++;
      else break;
    end
    check("R2 R7", "alloc_tag", 64'(alloc_tag), 64'(mt));
    check("R3 R10", "dispatch_stall", 64'(dispatch_stall), 64'(e_stall));
    check("R4 R5", "ret_cnt", 64'(ret_cnt), 64'(e_rc));
    if (e_rc > 0) check("R5", "ret_base", 64'(ret_base), 64'(mh));
    check("R6 R8", "exc_valid", 64'(exc_valid), 64'(e_exc));
    if (e_exc) begin
      check("R6", "exc_pc", 64'(exc_pc), 64'(mpc[mh]));
      check("R6", "exc_tag", 64'(exc_tag), 64'(mh));
    end
    check("R9", "proto_err", 64'(proto_err),
          64'(chk_valid && !(mv[chk_tag] && md[chk_tag])));
  endtask

  task automatic update_model();
    bit fire = alloc_valid && !e_stall;
    if (chk_valid && mv[chk_tag] && md[chk_tag]) begin
      mc[chk_tag] = 1'b1;
      mb[chk_tag] = (chk_data != mres[chk_tag]);
    end
    if (cmp_valid && mv[cmp_tag]) begin
      md[cmp_tag]   = 1'b1;
      mres[cmp_tag] = cmp_data;
    end
    if (e_exc) begin
      for (int k = 0; k < DEPTH; k++) begin
        mv[k] = 0; md[k] = 0; mc[k] = 0; mb[k] = 0;
      end
      mt = mh;
      mn = 0;
    end else begin
      for (int i = 0; i < e_rc; i++) begin
        int k = (mh + i) % DEPTH;
        mv[k] = 0; md[k] = 0; mc[k] = 0; mb[k] = 0;
      end
      mh = (mh + e_rc) % DEPTH;
      mn = mn - e_rc;
      if (fire) begin
        mv[mt] = 1; md[mt] = 0; mc[mt] = 0; mb[mt] = 0;
        mpc[mt] = alloc_pc;
        mt = (mt + 1) % DEPTH;
        mn++;
      end
    end
    if (mn > DEPTH) begin
      n_bad++;
      $display("FAIL R10 occupancy: actual %0d expected <= %0d", mn, DEPTH);
    end
  endtask

  // one cycle: inputs already driven; compare late in the cycle, then step
  task automatic cycle();
    #3;
    expect_now();
    @(posedge clk);
    update_model();
    #1;
  endtask

  task automatic drive_rand();
    int s;
    alloc_valid = ($urandom_range(99) < p_alloc);
    alloc_pc    = $urandom;
    cmp_valid = 1'b0;
    chk_valid = 1'b0;
    if ($urandom_range(99) < p_cmp) begin
      s = $urandom_range(DEPTH - 1);
      for (int i = 0; i < DEPTH; i++) begin
        int k = (s + i) % DEPTH;
        if (mv[k] && !md[k]) begin
          cmp_valid = 1'b1; cmp_tag = 6'(k); cmp_data = $urandom; break;
        end
      end
    end
    if ($urandom_range(99) < p_proto) begin
      chk_valid = 1'b1;
      chk_tag   = 6'($urandom_range(DEPTH - 1));
      chk_data  = $urandom;
    end else if ($urandom_range(99) < p_chk) begin
      s = $urandom_range(DEPTH - 1);
      for (int i = 0; i < DEPTH; i++) begin
        int k = (s + i) % DEPTH;
        if (mv[k] && md[k] && !mc[k]) begin
          chk_valid = 1'b1; chk_tag = 6'(k);
          chk_data  = ($urandom_range(99) < p_bad) ? (mres[k] ^ 32'h1) : mres[k];
          break;
        end
      end
    end
  endtask

  task automatic run_phase(input int cycles, input int pa, input int pc,
                           input int pk, input int pb, input int pp);
    p_alloc = pa; p_cmp = pc; p_chk = pk; p_bad = pb; p_proto = pp;
    for (int c = 0; c < cycles; c++) begin
      drive_rand();
      cycle();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mv[k] = 0; md[k] = 0; mc[k] = 0; mb[k] = 0; mres[k] = '0; mpc[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while reset is held
    check("R1", "alloc_tag", 64'(alloc_tag), 64'd0);
    check("R1", "dispatch_stall", 64'(dispatch_stall), 64'd0);
    check("R1", "ret_cnt", 64'(ret_cnt), 64'd0);
    check("R1", "exc_valid", 64'(exc_valid), 64'd0);
    check("R1", "proto_err", 64'(proto_err), 64'd0);
    rst_n = 1'b1;
    #1;
    // fill with completions but no checks: nothing may retire, then stall
    run_phase(120, 100, 70, 0, 0, 0);
    // R3: full buffer
    check("R3", "full after fill", 64'(dispatch_stall), 64'd1);
    // drain with matching checks: retire bursts
    run_phase(150, 0, 100, 100, 0, 0);
    check("R5", "drained empty", 64'(mn), 64'd0);
    // mixed traffic with mismatches and premature checks
    run_phase(3000, 70, 80, 80, 3, 5);
    // run-ahead heavy traffic with rare faults
    run_phase(2000, 90, 50, 30, 1, 2);
    // finish all outstanding work
    run_phase(300, 0, 100, 100, 0, 0);
    summary();
    $finish;
  end

endmodule